// File: doc/BRIEF.md
# Byte-Lane Write Strobe Generator

This block drives the two active-low write-control pins of an external memory bus whose data path is either 8 or 16 bits wide. Each write request is described by four things: the bus width of the cycle, a word/byte size flag, address bit 0, and a strobe-mode configuration bit. For a byte access, address bit 0 picks the lane: 0 selects the low byte and 1 selects the high byte.

The block runs every accepted write as a fixed three-clock cycle. The first clock sets up the address. In the second clock the strobe is asserted. In the third the strobe is released while data is still held, and a one-clock done pulse is raised.

The mode bit sets the meaning of the pins. With the bit at 0, the pins are two separate strobes, one for the low byte and one for the high byte. With the bit at 1, the low pin becomes a single write strobe and the high pin becomes a high-byte enable. The high-byte enable stays asserted for the whole cycle.

Top module: `wstrobe_gen`

## Requirements
- R1: Out of reset, and whenever no cycle is in progress, both pins are high (inactive), `ready_o` is 1 and `done_o` is 0.
- R2: A request sampled high at a rising edge while `ready_o` is 1 starts a cycle. After that edge the cycle passes through a setup clock, a strobe clock and a hold clock. `ready_o` is 0 for all three clocks, and no write strobe is low outside the strobe clock.
- R3: In split mode (`combined_i`=0) on a 16-bit cycle (`wide_i`=1), the low pin goes low in the strobe clock only for word writes (`word_i`=1) and for byte writes with `addr0_i`=0.
- R4: In split mode on a 16-bit cycle, the high pin goes low in the strobe clock only for word writes and for byte writes with `addr0_i`=1.
- R5: In split mode on an 8-bit cycle (`wide_i`=0), both pins go low in the strobe clock for every write, whatever `word_i` and `addr0_i` are.
- R6: In combined mode (`combined_i`=1), the low pin is the single write strobe and goes low in the strobe clock for every write.
- R7: In combined mode, the high pin is the high-byte enable. It is low for all three clocks of a cycle that is a word write or a byte write with `addr0_i`=1, and high for a byte write with `addr0_i`=0.
- R8: The mode bit and the cycle attributes are sampled only while idle. A change of `combined_i` during a cycle has no effect on the pins until that cycle is over.
- R9: A request raised while a cycle is in progress is not accepted and is not remembered. If the request is gone by the time `ready_o` returns to 1, no further cycle follows.
- R10: `done_o` is high for exactly the hold clock of each cycle and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Write request, level sampled while ready |
| wide_i | input | 1 | 1 = 16-bit bus cycle, 0 = 8-bit |
| word_i | input | 1 | 1 = word write, 0 = byte write |
| addr0_i | input | 1 | Address bit 0; picks the byte lane for byte writes |
| combined_i | input | 1 | Pin mode: 0 = split byte strobes, 1 = single strobe plus high-byte enable |
| ready_o | output | 1 | High when a new request can be accepted |
| done_o | output | 1 | One-clock pulse in the last clock of a cycle |
| pin_hi_n_o | output | 1 | High-byte strobe or high-byte enable, active low |
| pin_lo_n_o | output | 1 | Low-byte strobe or single write strobe, active low |

## Verification
A corrupt phase register would show up at the pins within a single clock. The strobe would appear in the setup or hold clock, `done_o` would land in the wrong clock, or `ready_o` would return early. A wrong latched attribute or mode bit would show during the same cycle as the wrong pin pattern in the strobe clock, or, in combined mode, as the high-byte enable being wrong from the setup clock onward. Sampling the pins in every phase of each cycle, and flipping the mode input in the middle of a cycle, exposes both kinds of fault within at most three clocks of the request.

// File: rtl/wstrobe_pkg.sv
// Shared types for the write strobe generator.
// Assumes: one cycle in flight at a time.
package wstrobe_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    typedef struct packed {
        logic wide;      // 1 = 16-bit bus cycle
        logic word;      // 1 = word write
        logic addr0;     // byte lane for byte writes
        logic combined;  // pin mode
    } wr_ctx_t;
endpackage

// File: rtl/wstrobe_seq.sv
// Cycle sequencer: accepts a request while idle, then steps through the
// setup, strobe and hold phases. It freezes the attributes and the mode
// bit for the length of the cycle.
// Assumes: synchronous active-low reset; inputs are valid at each edge.
module wstrobe_seq
    import wstrobe_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_i,
    input  wr_ctx_t ctx_i,
    output phase_e  phase_o,
    output wr_ctx_t ctx_o,
    output logic    ready_o,
    output logic    done_o
);
    phase_e  phase_q;
    wr_ctx_t ctx_q;

    // Phase register: idle -> setup -> strobe -> hold -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            unique case (phase_q)
                PH_IDLE:   if (req_i) phase_q <= PH_SETUP;
                PH_SETUP:  phase_q <= PH_STROBE;
                PH_STROBE: phase_q <= PH_HOLD;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    // Attribute and mode capture, allowed only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (phase_q == PH_IDLE) begin
            ctx_q <= ctx_i;
        end
    end

    assign phase_o = phase_q;
    assign ctx_o   = ctx_q;
    assign ready_o = (phase_q == PH_IDLE);
    assign done_o  = (phase_q == PH_HOLD);

    // R2: the three phases follow in a fixed order.
    assert_phase_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SETUP) |=> (phase_q == PH_STROBE));
    assert_phase_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STROBE) |=> (phase_q == PH_HOLD));
    assert_phase_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD) |=> (phase_q == PH_IDLE));
    // R8: the latched context does not move during a cycle.
    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> $stable(ctx_q));
endmodule

// File: rtl/wstrobe_lane_decode.sv
// Lane decoder: from the latched attributes it works out which byte
// lanes the write touches and whether the high-byte enable applies.
// Assumes: on an 8-bit bus every write drives both byte strobes.
module wstrobe_lane_decode
    import wstrobe_pkg::*;
(
    input  wr_ctx_t ctx_i,
    output logic    lo_en_o,
    output logic    hi_en_o,
    output logic    hbe_en_o
);
    // Lane enables from bus width, size and address bit 0.
    always_comb begin
        lo_en_o  = !ctx_i.wide || ctx_i.word || !ctx_i.addr0;
        hi_en_o  = !ctx_i.wide || ctx_i.word ||  ctx_i.addr0;
        hbe_en_o = ctx_i.word || ctx_i.addr0;
    end
endmodule

// File: rtl/wstrobe_pin_mux.sv
// Pin mapper: turns the phase and the lane enables into the two
// active-low pins, choosing between split-strobe and combined meaning.
// Assumes: the phase and the enables come from registers, so the pins
// do not depend on the live inputs.
module wstrobe_pin_mux
    import wstrobe_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_e phase_i,
    input  logic   combined_i,
    input  logic   wide_i,
    input  logic   lo_en_i,
    input  logic   hi_en_i,
    input  logic   hbe_en_i,
    output logic   pin_hi_n_o,
    output logic   pin_lo_n_o
);
    logic strobe_win;
    logic cycle_win;

    // Phase windows: the strobe clock, and the whole bus cycle.
    always_comb begin
        strobe_win = (phase_i == PH_STROBE);
        cycle_win  = (phase_i != PH_IDLE);
    end

    // Pin meaning chosen by the latched mode bit.
    always_comb begin
        if (combined_i) begin
            pin_hi_n_o = !(cycle_win && hbe_en_i);
            pin_lo_n_o = !strobe_win;
        end else begin
            pin_hi_n_o = !(strobe_win && hi_en_i);
            pin_lo_n_o = !(strobe_win && lo_en_i);
        end
    end

    // R5: an 8-bit split cycle drives both strobes together.
    assert_split_narrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_win && !combined_i && !wide_i) |-> (!pin_hi_n_o && !pin_lo_n_o));
    // R3/R4: a 16-bit split strobe always drives at least one lane.
    assert_split_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_win && !combined_i) |-> (!pin_hi_n_o || !pin_lo_n_o));
    // R6: in combined mode the write strobe is low exactly in the strobe clock.
    assert_comb_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        combined_i |-> (pin_lo_n_o == (phase_i != PH_STROBE)));
endmodule

// File: rtl/wstrobe_gen.sv
// Top of the write strobe generator. The sequencer, the lane decoder
// and the pin mapper are wired here.
// Assumes: synchronous active-low reset; one write in flight at a time.
module wstrobe_gen
    import wstrobe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic wide_i,
    input  logic word_i,
    input  logic addr0_i,
    input  logic combined_i,
    output logic ready_o,
    output logic done_o,
    output logic pin_hi_n_o,
    output logic pin_lo_n_o
);
    wr_ctx_t ctx_in;
    wr_ctx_t ctx_q;
    phase_e  phase;
    logic    lo_en;
    logic    hi_en;
    logic    hbe_en;

    // Bundle the request attributes.
    always_comb begin
        ctx_in.wide     = wide_i;
        ctx_in.word     = word_i;
        ctx_in.addr0    = addr0_i;
        ctx_in.combined = combined_i;
    end

    wstrobe_seq seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .ctx_i   (ctx_in),
        .phase_o (phase),
        .ctx_o   (ctx_q),
        .ready_o (ready_o),
        .done_o  (done_o)
    );

    wstrobe_lane_decode dec_i (
        .ctx_i    (ctx_q),
        .lo_en_o  (lo_en),
        .hi_en_o  (hi_en),
        .hbe_en_o (hbe_en)
    );

    wstrobe_pin_mux mux_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .combined_i (ctx_q.combined),
        .wide_i     (ctx_q.wide),
        .lo_en_i    (lo_en),
        .hi_en_i    (hi_en),
        .hbe_en_i   (hbe_en),
        .pin_hi_n_o (pin_hi_n_o),
        .pin_lo_n_o (pin_lo_n_o)
    );

    // R1: idle means both pins inactive and no done pulse.
    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (pin_hi_n_o && pin_lo_n_o && !done_o));
    // R10: done never lasts two clocks.
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9: a busy cycle keeps ready low until its hold clock is over.
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !done_o) |=> !ready_o);
endmodule

// File: tb/wstrobe_gen_tb_top.sv
// Directed bench for the write strobe generator.
module wstrobe_gen_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wide = 1'b0, word = 1'b0, a0 = 1'b0, comb = 1'b0;
    logic ready, done, pin_hi_n, pin_lo_n;
    int   n_chk = 0;
    int   n_bad = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    wstrobe_gen dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .wide_i     (wide),
        .word_i     (word),
        .addr0_i    (a0),
        .combined_i (comb),
        .ready_o    (ready),
        .done_o     (done),
        .pin_hi_n_o (pin_hi_n),
        .pin_lo_n_o (pin_lo_n)
    );

    // Compare {ready, done, hi_n, lo_n} against the expected value.
    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {ready, done, pin_hi_n, pin_lo_n};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {rdy,done,hi_n,lo_n} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One complete write, with every phase checked against the model
    // taken from the requirements.
    task automatic do_write(input string tag, input logic w16, input logic wd,
                            input logic ad, input logic cm);
        logic lo_on, hi_on, hbe;
        logic [3:0] e_set, e_stb, e_hld;
        lo_on = !w16 || wd || !ad;
        hi_on = !w16 || wd || ad;
        hbe   = wd || ad;
        if (cm) begin
            e_set = {2'b00, !hbe, 1'b1};
            e_stb = {2'b00, !hbe, 1'b0};
            e_hld = {2'b01, !hbe, 1'b1};
        end else begin
            e_set = 4'b0011;
            e_stb = {2'b00, !hi_on, !lo_on};
            e_hld = 4'b0111;
        end
        @(negedge clk);
        wide = w16; word = wd; a0 = ad; comb = cm; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " setup"}, e_set);
        @(negedge clk);
        chk({tag, " strobe"}, e_stb);
        @(negedge clk);
        chk({tag, " hold"}, e_hld);
        @(negedge clk);
        chk({tag, " back idle R1"}, 4'b1011);
    endtask

    // R8: flipping the mode bit mid-cycle must not change this cycle's pins.
    task automatic mode_flip_mid_cycle();
        @(negedge clk);
        wide = 1'b1; word = 1'b0; a0 = 1'b1; comb = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0; comb = 1'b1;
        chk("R8 setup keeps split", 4'b0011);
        @(negedge clk);
        chk("R8 strobe keeps split", 4'b0001);
        @(negedge clk);
        chk("R8 hold keeps split", 4'b0111);
        @(negedge clk);
        comb = 1'b0;
        chk("R8 idle after", 4'b1011);
    endtask

    // R9: a request pulse during a busy cycle is dropped.
    task automatic busy_request();
        @(negedge clk);
        wide = 1'b1; word = 1'b1; a0 = 1'b0; comb = 1'b0; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        req = 1'b1;
        chk("R9 ready low while busy", 4'b0000);
        @(negedge clk);
        req = 1'b0;
        chk("R9 hold", 4'b0111);
        @(negedge clk);
        chk("R9 idle", 4'b1011);
        @(negedge clk);
        chk("R9 no second cycle", 4'b1011);
        @(negedge clk);
        chk("R9 still idle", 4'b1011);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset state", 4'b1011);
        @(negedge clk);
        chk("R1 idle without request", 4'b1011);
        // R2 R3 R4: 16-bit split-mode lanes
        do_write("R3 split16 low byte", 1'b1, 1'b0, 1'b0, 1'b0);
        do_write("R4 split16 high byte", 1'b1, 1'b0, 1'b1, 1'b0);
        do_write("R2 R3 R4 split16 word", 1'b1, 1'b1, 1'b0, 1'b0);
        // R5: 8-bit cycles drive both strobes
        do_write("R5 split8 byte a0=0", 1'b0, 1'b0, 1'b0, 1'b0);
        do_write("R5 split8 byte a0=1", 1'b0, 1'b0, 1'b1, 1'b0);
        do_write("R5 split8 word", 1'b0, 1'b1, 1'b0, 1'b0);
        // R6 R7: combined mode
        do_write("R6 R7 comb16 word", 1'b1, 1'b1, 1'b0, 1'b1);
        do_write("R6 R7 comb16 high", 1'b1, 1'b0, 1'b1, 1'b1);
        do_write("R6 R7 comb16 low", 1'b1, 1'b0, 1'b0, 1'b1);
        do_write("R6 R7 comb8 low", 1'b0, 1'b0, 1'b0, 1'b1);
        do_write("R10 comb8 high", 1'b0, 1'b0, 1'b1, 1'b1);
        mode_flip_mid_cycle();
        busy_request();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule